// File: doc/BRIEF.md
# Priority Memory Chip-Select Decoder

This block turns a 16-bit CPU address, together with the CPU's fetch, read and write strobes, into one-hot chip selects. The outputs go to an SRAM, an I/O window, a peripheral I/O window, a bank of secondary flash sectors and a bank of primary flash sectors. Software describes every region with an enable, a first address and a last address (inclusive). Regions may overlap across priority levels, and a fixed three-level ladder settles which one wins. The SRAM and the two I/O windows sit on the top level, secondary flash sits in the middle, and primary flash sits at the bottom.

Program space and data space are separate. A 6-bit space-mapping register states whether each of three banks answers program fetches, data accesses, or both. The three banks are primary flash, secondary flash and SRAM. The register loads a parameterised boot value at reset, and the CPU can rewrite it at any time, for example to swap the two flash banks between the spaces. The decode path itself is purely combinational. Only the region table and the mapping register are clocked.

Top module: `memsel_decoder`

## Requirements
- R1: When an enabled SRAM, I/O or peripheral I/O region matches the address in the current space, that level-one select is asserted and no flash select is asserted.
- R2: When a secondary sector and a primary sector both match and no level-one region matches, only the secondary select is asserted.
- R3: At most one select output is active at any time. If two regions on the same level both match, the one with the lower table index wins.
- R4: With fetch_i, rd_i and wr_i all low, no select is asserted and no_hit_o stays low.
- R5: During an access that matches no enabled region in the current space, no select is asserted and no_hit_o is high.
- R6: fetch_i high marks a program-space access and takes precedence over the other strobes. Otherwise rd_i or wr_i high marks a data-space access. The mapping register bits are: bit0 primary flash in program space, bit1 primary flash in data space, bit2 secondary flash in program space, bit3 secondary flash in data space, bit4 SRAM in program space, bit5 SRAM in data space. I/O and peripheral I/O answer only in data space.
- R7: The mapping register holds MAP_RESET after reset. A write with map_we_i changes the decode from the clock edge that ends the write cycle onward, and never earlier.
- R8: A region write with cfg_en_i high is rejected when the last address is below the first address, or when a flash sector's span exceeds its physical sector size (PRI_SECT_BYTES or SEC_SECT_BYTES). On rejection cfg_reject_o is high in that cycle and the table entry keeps its old value.
- R9: cfg_overlap_o is high while two enabled regions on the same level overlap in a space that both of them answer. Overlaps between different levels never raise it.
- R10: With primary sector 0 at 8000h–BFFFh, secondary sector 0 at 8000h–9FFFh, SRAM at 8000h–87FFh, and all banks mapped to data space, a data access decodes as follows. 8000h–87FFh selects SRAM, 8800h–9FFFh selects secondary sector 0, and A000h–BFFFh selects primary sector 0.
- R11: Every region resets to disabled. cfg_idx_i addresses table entries in this order: 0 SRAM, 1 I/O, 2 peripheral I/O, then secondary sectors 3 to 3+N_SEC-1, then primary sectors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | CPU address |
| fetch_i | input | 1 | Program fetch strobe |
| rd_i | input | 1 | Data read strobe |
| wr_i | input | 1 | Data write strobe |
| cfg_we_i | input | 1 | Region table write |
| cfg_idx_i | input | IDX_W | Table entry to write |
| cfg_en_i | input | 1 | Enable value for the entry |
| cfg_base_i | input | 16 | First address of the region |
| cfg_limit_i | input | 16 | Last address of the region, inclusive |
| map_we_i | input | 1 | Mapping register write |
| map_d_i | input | 6 | New mapping register value |
| ram_sel_o | output | 1 | SRAM select |
| io_sel_o | output | 1 | I/O select |
| pio_sel_o | output | 1 | Peripheral I/O select |
| sec_sel_o | output | N_SEC | Secondary sector selects |
| pri_sel_o | output | N_PRI | Primary sector selects |
| no_hit_o | output | 1 | Access matched no region |
| cfg_reject_o | output | 1 | Current region write is rejected |
| cfg_overlap_o | output | 1 | Same-level overlap present |

## Verification
Some properties are checked by assertions on every cycle. The selects are checked to be one-hot or idle, the ladder is checked never to let a lower level through while a higher level matches, and an idle bus is checked to give no output. The assertions also confirm that a mapping write shows up exactly one edge later and that a rejected write leaves the table untouched.

Other behaviour needs the bench's scenarios with concrete tables. These include the exact address boundaries of the worked overlap case, the gating of each bank by space, and which lower-index region wins a same-level tie. The overlap flag for particular configurations and the size-limit rejection at one byte over the sector size are also shown only by the scenarios.

// File: rtl/memsel_pkg.sv
package memsel_pkg;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned MAP_W  = 6;
  localparam int unsigned NUM_L1 = 3;

  localparam int unsigned MAP_PRI_P = 0;
  localparam int unsigned MAP_PRI_D = 1;
  localparam int unsigned MAP_SEC_P = 2;
  localparam int unsigned MAP_SEC_D = 3;
  localparam int unsigned MAP_RAM_P = 4;
  localparam int unsigned MAP_RAM_D = 5;

  typedef struct packed {
    logic              en;
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] limit;
  } region_t;

  // level: 1 = sram/io/pio, 2 = secondary, 3 = primary
  function automatic int unsigned region_level(int unsigned idx, int unsigned n_sec);
    if (idx < NUM_L1) return 1;
    if (idx < NUM_L1 + n_sec) return 2;
    return 3;
  endfunction

  // returns {data, prog}
  function automatic logic [1:0] region_space(int unsigned idx, int unsigned n_sec,
                                              logic [MAP_W-1:0] map);
    if (idx == 0) return {map[MAP_RAM_D], map[MAP_RAM_P]};
    if (idx < NUM_L1) return 2'b10;
    if (idx < NUM_L1 + n_sec) return {map[MAP_SEC_D], map[MAP_SEC_P]};
    return {map[MAP_PRI_D], map[MAP_PRI_P]};
  endfunction
endpackage

// File: rtl/memsel_cfg_regs.sv
module memsel_cfg_regs
  import memsel_pkg::*;
#(
  parameter int unsigned N_PRI          = 8,
  parameter int unsigned N_SEC          = 4,
  parameter int unsigned PRI_SECT_BYTES = 16384,
  parameter int unsigned SEC_SECT_BYTES = 8192,
  parameter logic [MAP_W-1:0] MAP_RESET = 6'b100110,
  parameter int unsigned N_REG          = NUM_L1 + N_SEC + N_PRI,
  parameter int unsigned IDX_W          = $clog2(N_REG)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   cfg_we_i,
  input  logic [IDX_W-1:0]       cfg_idx_i,
  input  logic                   cfg_en_i,
  input  logic [ADDR_W-1:0]      cfg_base_i,
  input  logic [ADDR_W-1:0]      cfg_limit_i,
  input  logic                   map_we_i,
  input  logic [MAP_W-1:0]       map_d_i,
  output region_t [N_REG-1:0]    regions_o,
  output logic [MAP_W-1:0]       map_o,
  output logic                   cfg_reject_o
);
  localparam logic [ADDR_W:0] PRI_LIM = (ADDR_W+1)'(PRI_SECT_BYTES);
  localparam logic [ADDR_W:0] SEC_LIM = (ADDR_W+1)'(SEC_SECT_BYTES);
  localparam int unsigned SEC_LO = NUM_L1;
  localparam int unsigned PRI_LO = NUM_L1 + N_SEC;

  region_t [N_REG-1:0] regions_q;
  logic [MAP_W-1:0]    map_q;
  logic [ADDR_W:0]     span;
  logic                idx_valid, is_sec, is_pri, bad_order, too_big;

  always_comb begin
    span      = {1'b0, cfg_limit_i} - {1'b0, cfg_base_i} + (ADDR_W+1)'(1);
    idx_valid = 32'(cfg_idx_i) < N_REG;
    is_sec    = 32'(cfg_idx_i) >= SEC_LO && 32'(cfg_idx_i) < PRI_LO;
    is_pri    = 32'(cfg_idx_i) >= PRI_LO && idx_valid;
    bad_order = cfg_limit_i < cfg_base_i;
    too_big   = (is_sec && span > SEC_LIM) || (is_pri && span > PRI_LIM);
    cfg_reject_o = cfg_we_i && (!idx_valid || (cfg_en_i && (bad_order || too_big)));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      regions_q <= '0;
    end else if (cfg_we_i && !cfg_reject_o) begin
      regions_q[cfg_idx_i] <= '{en: cfg_en_i, base: cfg_base_i, limit: cfg_limit_i};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) map_q <= MAP_RESET;
    else if (map_we_i) map_q <= map_d_i;
  end

  assign regions_o = regions_q;
  assign map_o     = map_q;

  p_map_next_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    map_we_i |=> map_o == $past(map_d_i));

  p_map_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !map_we_i |=> $stable(map_o));

  p_reject_keeps_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_reject_o |=> $stable(regions_o));
endmodule

// File: rtl/memsel_match.sv
module memsel_match
  import memsel_pkg::*;
#(
  parameter int unsigned N_PRI = 8,
  parameter int unsigned N_SEC = 4,
  parameter int unsigned N_REG = NUM_L1 + N_SEC + N_PRI
) (
  input  region_t [N_REG-1:0] regions_i,
  input  logic [MAP_W-1:0]    map_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                acc_prog_i,
  input  logic                acc_data_i,
  output logic [NUM_L1-1:0]   l1_hit_o,
  output logic [N_SEC-1:0]    sec_hit_o,
  output logic [N_PRI-1:0]    pri_hit_o
);
  logic [N_REG-1:0] hit;

  for (genvar g = 0; g < N_REG; g++) begin : g_reg
    logic [1:0] sp;
    logic       in_rng, sp_ok;
    assign sp     = region_space(g, N_SEC, map_i);
    assign in_rng = addr_i >= regions_i[g].base && addr_i <= regions_i[g].limit;
    assign sp_ok  = (acc_prog_i && sp[0]) || (acc_data_i && sp[1]);
    assign hit[g] = regions_i[g].en && in_rng && sp_ok;
  end

  assign l1_hit_o  = hit[NUM_L1-1:0];
  assign sec_hit_o = hit[NUM_L1 +: N_SEC];
  assign pri_hit_o = hit[NUM_L1+N_SEC +: N_PRI];
endmodule

// File: rtl/memsel_prio.sv
module memsel_prio
  import memsel_pkg::*;
#(
  parameter int unsigned N_PRI = 8,
  parameter int unsigned N_SEC = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic [NUM_L1-1:0] l1_hit_i,
  input  logic [N_SEC-1:0]  sec_hit_i,
  input  logic [N_PRI-1:0]  pri_hit_i,
  output logic [NUM_L1-1:0] l1_sel_o,
  output logic [N_SEC-1:0]  sec_sel_o,
  output logic [N_PRI-1:0]  pri_sel_o,
  output logic              no_hit_o
);
  logic any_l1, any_sec, any_pri;

  always_comb begin
    any_l1  = |l1_hit_i;
    any_sec = |sec_hit_i;
    any_pri = |pri_hit_i;
    // keep lowest set bit of each level
    l1_sel_o  = l1_hit_i & (~l1_hit_i + NUM_L1'(1));
    sec_sel_o = any_l1 ? '0 : (sec_hit_i & (~sec_hit_i + N_SEC'(1)));
    pri_sel_o = (any_l1 || any_sec) ? '0 : (pri_hit_i & (~pri_hit_i + N_PRI'(1)));
    no_hit_o  = active_i && !any_l1 && !any_sec && !any_pri;
  end

  p_onehot_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({l1_sel_o, sec_sel_o, pri_sel_o, no_hit_o}));

  p_l1_wins_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|l1_hit_i) |-> (sec_sel_o == '0 && pri_sel_o == '0 && $onehot(l1_sel_o)));

  p_sec_over_pri_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|sec_hit_i) && !(|l1_hit_i)) |-> (pri_sel_o == '0 && $onehot(sec_sel_o)));
endmodule

// File: rtl/memsel_overlap.sv
module memsel_overlap
  import memsel_pkg::*;
#(
  parameter int unsigned N_PRI = 8,
  parameter int unsigned N_SEC = 4,
  parameter int unsigned N_REG = NUM_L1 + N_SEC + N_PRI
) (
  input  region_t [N_REG-1:0] regions_i,
  input  logic [MAP_W-1:0]    map_i,
  output logic                overlap_o
);
  always_comb begin
    overlap_o = 1'b0;
    for (int unsigned i = 0; i < N_REG; i++) begin
      for (int unsigned j = i + 1; j < N_REG; j++) begin
        if (region_level(i, N_SEC) == region_level(j, N_SEC) &&
            regions_i[i].en && regions_i[j].en &&
            (region_space(i, N_SEC, map_i) & region_space(j, N_SEC, map_i)) != 2'b00 &&
            regions_i[i].base <= regions_i[j].limit &&
            regions_i[j].base <= regions_i[i].limit)
          overlap_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/memsel_decoder.sv
module memsel_decoder
  import memsel_pkg::*;
#(
  parameter int unsigned N_PRI          = 8,
  parameter int unsigned N_SEC          = 4,
  parameter int unsigned PRI_SECT_BYTES = 16384,
  parameter int unsigned SEC_SECT_BYTES = 8192,
  parameter logic [MAP_W-1:0] MAP_RESET = 6'b100110,
  parameter int unsigned IDX_W          = $clog2(NUM_L1 + N_SEC + N_PRI)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              fetch_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic              cfg_we_i,
  input  logic [IDX_W-1:0]  cfg_idx_i,
  input  logic              cfg_en_i,
  input  logic [ADDR_W-1:0] cfg_base_i,
  input  logic [ADDR_W-1:0] cfg_limit_i,
  input  logic              map_we_i,
  input  logic [MAP_W-1:0]  map_d_i,
  output logic              ram_sel_o,
  output logic              io_sel_o,
  output logic              pio_sel_o,
  output logic [N_SEC-1:0]  sec_sel_o,
  output logic [N_PRI-1:0]  pri_sel_o,
  output logic              no_hit_o,
  output logic              cfg_reject_o,
  output logic              cfg_overlap_o
);
  localparam int unsigned N_REG = NUM_L1 + N_SEC + N_PRI;

  region_t [N_REG-1:0] regions;
  logic [MAP_W-1:0]    map_q;
  logic                acc_prog, acc_data;
  logic [NUM_L1-1:0]   l1_hit, l1_sel;
  logic [N_SEC-1:0]    sec_hit;
  logic [N_PRI-1:0]    pri_hit;

  assign acc_prog = fetch_i;
  assign acc_data = !fetch_i && (rd_i || wr_i);

  memsel_cfg_regs #(
    .N_PRI(N_PRI), .N_SEC(N_SEC), .PRI_SECT_BYTES(PRI_SECT_BYTES),
    .SEC_SECT_BYTES(SEC_SECT_BYTES), .MAP_RESET(MAP_RESET), .N_REG(N_REG), .IDX_W(IDX_W)
  ) u_cfg (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_idx_i, .cfg_en_i, .cfg_base_i, .cfg_limit_i,
    .map_we_i, .map_d_i, .regions_o(regions), .map_o(map_q), .cfg_reject_o
  );

  memsel_match #(.N_PRI(N_PRI), .N_SEC(N_SEC), .N_REG(N_REG)) u_match (
    .regions_i(regions), .map_i(map_q), .addr_i, .acc_prog_i(acc_prog),
    .acc_data_i(acc_data), .l1_hit_o(l1_hit), .sec_hit_o(sec_hit), .pri_hit_o(pri_hit)
  );

  memsel_prio #(.N_PRI(N_PRI), .N_SEC(N_SEC)) u_prio (
    .clk_i, .rst_ni, .active_i(acc_prog || acc_data), .l1_hit_i(l1_hit),
    .sec_hit_i(sec_hit), .pri_hit_i(pri_hit), .l1_sel_o(l1_sel),
    .sec_sel_o, .pri_sel_o, .no_hit_o
  );

  memsel_overlap #(.N_PRI(N_PRI), .N_SEC(N_SEC), .N_REG(N_REG)) u_ovl (
    .regions_i(regions), .map_i(map_q), .overlap_o(cfg_overlap_o)
  );

  assign ram_sel_o = l1_sel[0];
  assign io_sel_o  = l1_sel[1];
  assign pio_sel_o = l1_sel[2];

  p_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fetch_i || rd_i || wr_i) |->
      (!ram_sel_o && !io_sel_o && !pio_sel_o && sec_sel_o == '0 && pri_sel_o == '0 && !no_hit_o));

  p_nohit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    no_hit_o |-> (l1_hit == '0 && sec_hit == '0 && pri_hit == '0 && (fetch_i || rd_i || wr_i)));
endmodule

// File: tb/memsel_decoder_tb.sv
module memsel_decoder_tb;
  localparam int N_PRI = 8;
  localparam int N_SEC = 4;
  localparam int IDX_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic fetch = 0, rd = 0, wr = 0;
  logic cfg_we = 0, cfg_en = 0;
  logic [IDX_W-1:0] cfg_idx = '0;
  logic [15:0] cfg_base = '0, cfg_limit = '0;
  logic map_we = 0;
  logic [5:0] map_d = '0;
  logic ram_sel, io_sel, pio_sel, no_hit, reject, overlap;
  logic [N_SEC-1:0] sec_sel;
  logic [N_PRI-1:0] pri_sel;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  memsel_decoder u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .fetch_i(fetch), .rd_i(rd), .wr_i(wr),
    .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx), .cfg_en_i(cfg_en), .cfg_base_i(cfg_base),
    .cfg_limit_i(cfg_limit), .map_we_i(map_we), .map_d_i(map_d),
    .ram_sel_o(ram_sel), .io_sel_o(io_sel), .pio_sel_o(pio_sel), .sec_sel_o(sec_sel),
    .pri_sel_o(pri_sel), .no_hit_o(no_hit), .cfg_reject_o(reject), .cfg_overlap_o(overlap)
  );

  // word: [15] no_hit, [14] ram, [13] io, [12] pio, [11:8] sec, [7:0] pri
  localparam logic [15:0] W_NONE = 16'h0000;
  localparam logic [15:0] W_MISS = 16'h8000;
  localparam logic [15:0] W_RAM  = 16'h4000;
  localparam logic [15:0] W_IO   = 16'h2000;
  function automatic logic [15:0] w_sec(int k); return 16'(1) << (8 + k); endfunction
  function automatic logic [15:0] w_pri(int k); return 16'(1) << k; endfunction

  function automatic logic [15:0] observed();
    return {no_hit, ram_sel, io_sel, pio_sel, sec_sel, pri_sel};
  endfunction

  task automatic check_bit(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  // kind: 0 idle, 1 fetch, 2 read, 3 write, 4 fetch+read
  task automatic probe(string req, logic [15:0] a, int kind, logic [15:0] exp);
    @(negedge clk);
    addr = a; fetch = (kind == 1 || kind == 4); rd = (kind == 2 || kind == 4); wr = (kind == 3);
    #1;
    checks++;
    if (observed() !== exp) begin
      failures++;
      $display("FAIL %s addr=%h kind=%0d actual=%h expected=%h", req, a, kind, observed(), exp);
    end
  endtask

  task automatic wr_region(int idx, logic en, logic [15:0] b, logic [15:0] l, logic exp_rej,
                           string req);
    @(negedge clk);
    cfg_we = 1; cfg_idx = IDX_W'(idx); cfg_en = en; cfg_base = b; cfg_limit = l;
    #1 check_bit(req, "cfg_reject_o", reject, exp_rej);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic wr_map(logic [5:0] v);
    @(negedge clk);
    map_we = 1; map_d = v;
    @(negedge clk);
    map_we = 0;
  endtask

  task automatic t_reset();
    probe("R11", 16'h8000, 2, W_MISS);
    probe("R11", 16'h0000, 1, W_MISS);
    check_bit("R11", "cfg_overlap_o", overlap, 1'b0);
  endtask

  task automatic t_reset_map();
    // reset map 100110: pri data, sec prog, ram data (R7)
    wr_region(7, 1, 16'h8000, 16'hBFFF, 0, "R8");
    wr_region(3, 1, 16'h8000, 16'h9FFF, 0, "R8");
    probe("R7", 16'h8800, 1, w_sec(0));
    probe("R7", 16'h8800, 2, w_pri(0));
    probe("R7", 16'hA000, 1, W_MISS);
  endtask

  task automatic t_example();
    wr_region(0, 1, 16'h8000, 16'h87FF, 0, "R8");
    wr_map(6'b111111);
    probe("R10", 16'h8000, 2, W_RAM);
    probe("R10", 16'h87FF, 3, W_RAM);
    probe("R10", 16'h8800, 2, w_sec(0));
    probe("R10", 16'h9FFF, 2, w_sec(0));
    probe("R10", 16'hA000, 2, w_pri(0));
    probe("R10", 16'hBFFF, 3, w_pri(0));
    probe("R5", 16'hC000, 2, W_MISS);
    probe("R1", 16'h8400, 1, W_RAM);
    probe("R2", 16'h9000, 1, w_sec(0));
    check_bit("R9", "cross-level overlap flag", overlap, 1'b0);
  endtask

  task automatic t_idle();
    probe("R4", 16'h8000, 0, W_NONE);
    probe("R4", 16'hC000, 0, W_NONE);
  endtask

  task automatic t_space();
    wr_map(6'b000110); // pri data, sec prog, ram nowhere
    probe("R6", 16'h8800, 1, w_sec(0));
    probe("R6", 16'h8800, 2, w_pri(0));
    probe("R6", 16'hA000, 1, W_MISS);
    probe("R6", 16'h8000, 1, w_sec(0));
    probe("R6", 16'h8000, 3, w_pri(0));
    probe("R6", 16'h8800, 4, w_sec(0)); // fetch wins
  endtask

  task automatic t_map_timing();
    @(negedge clk);
    addr = 16'h8800; rd = 1; fetch = 0; wr = 0;
    map_we = 1; map_d = 6'b001001; // pri prog, sec data
    #1 checks++;
    if (observed() !== w_pri(0)) begin
      failures++;
      $display("FAIL R7 before edge actual=%h expected=%h", observed(), w_pri(0));
    end
    @(negedge clk);
    map_we = 0;
    #1 checks++;
    if (observed() !== w_sec(0)) begin
      failures++;
      $display("FAIL R7 after edge actual=%h expected=%h", observed(), w_sec(0));
    end
    probe("R7", 16'hA000, 1, w_pri(0));
  endtask

  task automatic t_reject();
    wr_map(6'b111111);
    wr_region(8, 1, 16'hC000, 16'hFFFF, 0, "R8");           // exactly 16K
    wr_region(4, 1, 16'hC000, 16'hE000, 1, "R8");           // 8K+1 secondary
    probe("R8", 16'hD000, 2, w_pri(1));
    wr_region(9, 1, 16'h0000, 16'h4000, 1, "R8");           // 16K+1 primary
    probe("R8", 16'h1000, 2, W_MISS);
    wr_region(1, 1, 16'h7000, 16'h6000, 1, "R8");           // reversed
    probe("R8", 16'h6800, 2, W_MISS);
  endtask

  task automatic t_overlap();
    wr_region(9, 1, 16'hC000, 16'hC0FF, 0, "R9");
    check_bit("R9", "pri overlap", overlap, 1'b1);
    probe("R3", 16'hC010, 2, w_pri(1));
    wr_region(9, 0, 16'hC000, 16'hC0FF, 0, "R9");
    check_bit("R9", "cleared", overlap, 1'b0);
    wr_region(1, 1, 16'h8000, 16'h80FF, 0, "R9");
    check_bit("R9", "ram/io overlap", overlap, 1'b1);
    probe("R3", 16'h8010, 2, W_RAM);
    probe("R1", 16'h8100, 2, W_RAM);
    wr_map(6'b011111); // ram out of data space
    check_bit("R9", "no shared space", overlap, 1'b0);
    probe("R1", 16'h8010, 2, W_IO);
    probe("R1", 16'h8010, 1, W_RAM);
  endtask

  initial begin
    #500_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_reset_map();
    t_example();
    t_idle();
    t_space();
    t_map_timing();
    t_reject();
    t_overlap();
    @(negedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule